// File: doc/BRIEF.md
# Branch Decode and Next-PC Unit

This block is a purely combinational stage that sits between instruction fetch and the program-counter register of a 64-bit core. It receives a 32-bit instruction word together with the address that word came from. It drives two register-file read indices and one condition-flag read index, and takes the values those reads return. From these it decides whether the word is one of thirteen control-transfer operations, whether the transfer is taken, and what the next program counter is.

The two linking operations also return a write-back request. A PC-relative call always links to register 1. A register-indirect jump links to a register chosen in the word. Words that are not control transfers fall through to the sequential address. All outputs settle within the same cycle as the inputs, so the caller registers `next_pc_o` as the new PC and commits the write-back request alongside it.

Top module: `brnpc_unit`

## Requirements
- R1: The major code in bits 31:26 selects the operation. 0x10 is branch-if-zero, 0x11 branch-if-nonzero, 0x13 indirect jump-and-link, 0x14 unconditional branch, 0x15 call, 0x16 equal, 0x17 not-equal, 0x18 signed less, 0x19 signed greater-or-equal, 0x1A unsigned less and 0x1B unsigned greater-or-equal. Every other major code gives `is_branch_o`=0, `taken_o`=0 and `wb_en_o`=0.
- R2: Branch-if-zero and branch-if-nonzero test the full register selected by bits 9:5 against zero. The offset is 21 bits: bits 4:0 form its upper 5 bits and bits 25:10 form its lower 16 bits. It is scaled by 4, sign-extended and added to the PC.
- R3: Major code 0x12 is a flag branch only when bit 9 is 0. With bit 8 at 0 it branches if the flag is clear; with bit 8 at 1 it branches if the flag is set. Bits 7:5 select one of eight flags on `flag_idx_o`, and the 21-bit offset is the same as in R2. Major code 0x12 with bit 9 at 1 is not a branch.
- R4: The equal and not-equal branches compare the two selected registers over all 64 bits. They add the 16-bit offset from bits 25:10, scaled by 4 and sign-extended, to the PC.
- R5: The signed less and signed greater-or-equal branches compare the operands as two's-complement 64-bit values.
- R6: The unsigned less and unsigned greater-or-equal branches compare the operands as unsigned 64-bit values.
- R7: Whenever `taken_o` is 0, `next_pc_o` equals the PC plus 4.
- R8: The unconditional branch is always taken. Its 26-bit offset has bits 9:0 as its upper 10 bits and bits 25:10 as its lower 16 bits. It is scaled by 4, sign-extended and added to the PC.
- R9: The call is taken with the R8 offset and requests a write of PC+4 to register 1.
- R10: The indirect jump sets the next PC to the value of the register in bits 9:5 plus the 16-bit offset, scaled by 4 and sign-extended. It requests a write of PC+4 to the register in bits 4:0, and the target uses that register's old value even when both fields name the same register.
- R11: A link write that targets register 0 is dropped: `wb_en_o` stays 0 while the jump still goes to its target.
- R12: `rs_a_idx_o` always carries bits 9:5 and `rs_b_idx_o` always carries bits 4:0 of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to classify |
| pc_i | input | 64 | Address of the instruction word |
| rs_a_idx_o | output | 5 | First register read index (bits 9:5) |
| rs_b_idx_o | output | 5 | Second register read index (bits 4:0) |
| rs_a_val_i | input | 64 | Value read for `rs_a_idx_o` |
| rs_b_val_i | input | 64 | Value read for `rs_b_idx_o` |
| flag_idx_o | output | 3 | Condition-flag read index (bits 7:5) |
| flag_val_i | input | 1 | Value of the selected condition flag |
| is_branch_o | output | 1 | Word is a control transfer |
| taken_o | output | 1 | Transfer goes to its target |
| next_pc_o | output | 64 | Address to fetch next |
| wb_en_o | output | 1 | Link write-back request |
| wb_idx_o | output | 5 | Link destination register |
| wb_data_o | output | 64 | Link value (PC+4) |

## Verification
The block holds no state, so any fault in decode, condition evaluation or target arithmetic shows up at the ports in the same cycle as the offending word. It cannot hide until a later cycle. A wrong operation class appears as a wrong `is_branch_o` or `wb_en_o`. A reversed comparison appears as a wrong `taken_o` together with a `next_pc_o` that is off by the offset. A badly reassembled offset field appears only for offsets whose upper field bits are non-zero, which is why the tests drive extreme positive and negative offsets and operand pairs that differ only in their sign bit.

// File: rtl/brnpc_pkg.sv
package brnpc_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_ZERO,
    OP_NONZERO,
    OP_FLAG_CLR,
    OP_FLAG_SET,
    OP_JUMP_REG,
    OP_JUMP,
    OP_CALL,
    OP_EQ,
    OP_NE,
    OP_LT,
    OP_GE,
    OP_LTU,
    OP_GEU
  } brnpc_op_e;

  localparam int NUM_MAJOR = 11;
  localparam logic [5:0] FLAG_MAJOR = 6'h12;

  localparam logic [5:0] MAJOR_CODE [NUM_MAJOR] = '{
    6'h10, 6'h11, 6'h13, 6'h14, 6'h15, 6'h16,
    6'h17, 6'h18, 6'h19, 6'h1A, 6'h1B
  };

  localparam brnpc_op_e MAJOR_OP [NUM_MAJOR] = '{
    OP_ZERO, OP_NONZERO, OP_JUMP_REG, OP_JUMP, OP_CALL, OP_EQ,
    OP_NE, OP_LT, OP_GE, OP_LTU, OP_GEU
  };

endpackage

// File: rtl/brnpc_decode.sv
module brnpc_decode
  import brnpc_pkg::*;
#(
  parameter int REG_IDX_W  = 5,
  parameter int FLAG_IDX_W = 3
) (
  input  logic [31:0]           instr_i,
  output brnpc_op_e             op_o,
  output logic                  is_branch_o,
  output logic [REG_IDX_W-1:0]  rj_idx_o,
  output logic [REG_IDX_W-1:0]  rd_idx_o,
  output logic [FLAG_IDX_W-1:0] flag_idx_o,
  output logic [15:0]           off16_o,
  output logic [20:0]           off21_o,
  output logic [25:0]           off26_o
);

  logic [5:0]           major;
  logic [NUM_MAJOR-1:0] hit;
  logic                 flag_hit;

  assign major    = instr_i[31:26];
  assign flag_hit = (major == FLAG_MAJOR) && !instr_i[9];

  for (genvar g = 0; g < NUM_MAJOR; g++) begin : g_match
    assign hit[g] = (major == MAJOR_CODE[g]);
  end

  always_comb begin
    op_o = OP_NONE;
    for (int i = 0; i < NUM_MAJOR; i++) begin
      if (hit[i]) op_o = MAJOR_OP[i];
    end
    if (flag_hit) op_o = instr_i[8] ? OP_FLAG_SET : OP_FLAG_CLR;
  end

  assign is_branch_o = (op_o != OP_NONE);
  assign rj_idx_o    = instr_i[9:5];
  assign rd_idx_o    = instr_i[4:0];
  assign flag_idx_o  = instr_i[7:5];
  assign off16_o     = instr_i[25:10];
  assign off21_o     = {instr_i[4:0], instr_i[25:10]};
  assign off26_o     = {instr_i[9:0], instr_i[25:10]};

  // R1: major-code patterns are disjoint, and none overlaps the flag class
  always_comb begin
    a_r1_single_match: assert ($onehot0({hit, flag_hit}))
      else $error("a_r1_single_match: overlapping decode");
  end

  // R3: a flag operation never comes from a word with bit 9 set
  always_comb begin
    if (op_o == OP_FLAG_CLR || op_o == OP_FLAG_SET) begin
      a_r3_flag_form: assert (major == FLAG_MAJOR && instr_i[9] == 1'b0)
        else $error("a_r3_flag_form: flag op from bad word");
    end
  end

endmodule

// File: rtl/brnpc_cond.sv
module brnpc_cond
  import brnpc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  brnpc_op_e       op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            flag_i,
  output logic            taken_o
);

  logic a_zero, eq, lt_s, lt_u;

  assign a_zero = (a_i == '0);
  assign eq     = (a_i == b_i);
  assign lt_s   = ($signed(a_i) < $signed(b_i));
  assign lt_u   = (a_i < b_i);

  always_comb begin
    unique case (op_i)
      OP_ZERO:     taken_o = a_zero;
      OP_NONZERO:  taken_o = !a_zero;
      OP_FLAG_CLR: taken_o = !flag_i;
      OP_FLAG_SET: taken_o = flag_i;
      OP_JUMP_REG,
      OP_JUMP,
      OP_CALL:     taken_o = 1'b1;
      OP_EQ:       taken_o = eq;
      OP_NE:       taken_o = !eq;
      OP_LT:       taken_o = lt_s;
      OP_GE:       taken_o = !lt_s;
      OP_LTU:      taken_o = lt_u;
      OP_GEU:      taken_o = !lt_u;
      default:     taken_o = 1'b0;
    endcase
  end

  // R1: a non-branch word is never taken
  always_comb begin
    if (op_i == OP_NONE) begin
      a_r1_none_not_taken: assert (!taken_o)
        else $error("a_r1_none_not_taken");
    end
  end

endmodule

// File: rtl/brnpc_target.sv
module brnpc_target
  import brnpc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  brnpc_op_e       op_i,
  input  logic            taken_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [15:0]     off16_i,
  input  logic [20:0]     off21_i,
  input  logic [25:0]     off26_i,
  output logic [XLEN-1:0] next_pc_o
);

  localparam int STEP = 4;

  logic [XLEN-1:0] ext16, ext21, ext26, seq_pc, tgt_pc;

  assign ext16  = {{(XLEN-18){off16_i[15]}}, off16_i, 2'b00};
  assign ext21  = {{(XLEN-23){off21_i[20]}}, off21_i, 2'b00};
  assign ext26  = {{(XLEN-28){off26_i[25]}}, off26_i, 2'b00};
  assign seq_pc = pc_i + XLEN'(STEP);

  always_comb begin
    unique case (op_i)
      OP_JUMP_REG:  tgt_pc = base_i + ext16;
      OP_ZERO, OP_NONZERO,
      OP_FLAG_CLR, OP_FLAG_SET:
                    tgt_pc = pc_i + ext21;
      OP_JUMP, OP_CALL:
                    tgt_pc = pc_i + ext26;
      OP_EQ, OP_NE, OP_LT, OP_GE, OP_LTU, OP_GEU:
                    tgt_pc = pc_i + ext16;
      default:      tgt_pc = seq_pc;
    endcase
  end

  assign next_pc_o = taken_i ? tgt_pc : seq_pc;

  // R8: PC-relative targets keep the word alignment of the PC
  always_comb begin
    if (taken_i && op_i != OP_JUMP_REG) begin
      a_r8_rel_aligned: assert (next_pc_o[1:0] == pc_i[1:0])
        else $error("a_r8_rel_aligned");
    end
  end

endmodule

// File: rtl/brnpc_unit.sv
module brnpc_unit
  import brnpc_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int REG_IDX_W  = 5,
  parameter int FLAG_IDX_W = 3,
  parameter int CALL_LINK  = 1
) (
  input  logic [31:0]           instr_i,
  input  logic [XLEN-1:0]       pc_i,
  output logic [REG_IDX_W-1:0]  rs_a_idx_o,
  output logic [REG_IDX_W-1:0]  rs_b_idx_o,
  input  logic [XLEN-1:0]       rs_a_val_i,
  input  logic [XLEN-1:0]       rs_b_val_i,
  output logic [FLAG_IDX_W-1:0] flag_idx_o,
  input  logic                  flag_val_i,
  output logic                  is_branch_o,
  output logic                  taken_o,
  output logic [XLEN-1:0]       next_pc_o,
  output logic                  wb_en_o,
  output logic [REG_IDX_W-1:0]  wb_idx_o,
  output logic [XLEN-1:0]       wb_data_o
);

  localparam logic [REG_IDX_W-1:0] LINK_REG = REG_IDX_W'(CALL_LINK);

  brnpc_op_e   op;
  logic [15:0] off16;
  logic [20:0] off21;
  logic [25:0] off26;
  logic        link_req;

  brnpc_decode #(
    .REG_IDX_W  (REG_IDX_W),
    .FLAG_IDX_W (FLAG_IDX_W)
  ) i_decode (
    .instr_i     (instr_i),
    .op_o        (op),
    .is_branch_o (is_branch_o),
    .rj_idx_o    (rs_a_idx_o),
    .rd_idx_o    (rs_b_idx_o),
    .flag_idx_o  (flag_idx_o),
    .off16_o     (off16),
    .off21_o     (off21),
    .off26_o     (off26)
  );

  brnpc_cond #(.XLEN(XLEN)) i_cond (
    .op_i    (op),
    .a_i     (rs_a_val_i),
    .b_i     (rs_b_val_i),
    .flag_i  (flag_val_i),
    .taken_o (taken_o)
  );

  // Target uses the read-port value, i.e. the register before any link write
  brnpc_target #(.XLEN(XLEN)) i_target (
    .op_i      (op),
    .taken_i   (taken_o),
    .pc_i      (pc_i),
    .base_i    (rs_a_val_i),
    .off16_i   (off16),
    .off21_i   (off21),
    .off26_i   (off26),
    .next_pc_o (next_pc_o)
  );

  assign link_req  = (op == OP_CALL) || (op == OP_JUMP_REG);
  assign wb_idx_o  = (op == OP_CALL) ? LINK_REG : rs_b_idx_o;
  assign wb_en_o   = link_req && (wb_idx_o != '0);
  assign wb_data_o = pc_i + XLEN'(4);

  // R7: fall-through when not taken
  always_comb begin
    if (!taken_o) begin
      a_r7_seq_when_not_taken: assert (next_pc_o == pc_i + XLEN'(4))
        else $error("a_r7_seq_when_not_taken");
    end
  end

  // R1: taken implies a recognised branch
  always_comb begin
    if (taken_o) begin
      a_r1_taken_is_branch: assert (is_branch_o)
        else $error("a_r1_taken_is_branch");
    end
  end

  // R11: never a write to register 0
  always_comb begin
    if (wb_en_o) begin
      a_r11_no_zero_write: assert (wb_idx_o != '0)
        else $error("a_r11_no_zero_write");
    end
  end

  // R9: a link write only accompanies a taken transfer
  always_comb begin
    if (wb_en_o) begin
      a_r9_link_taken: assert (taken_o && is_branch_o)
        else $error("a_r9_link_taken");
    end
  end

endmodule

// File: tb/test_brnpc_unit.sv
module test_brnpc_unit;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] instr;
  logic [63:0] pc;
  logic [4:0]  ra_idx, rb_idx, wb_idx;
  logic [63:0] ra_val, rb_val, next_pc, wb_data;
  logic [2:0]  f_idx;
  logic        f_val, is_br, taken, wb_en;

  logic [63:0] regs [32];
  logic [7:0]  flags;

  int checks = 0;
  int fails  = 0;

  assign ra_val = regs[ra_idx];
  assign rb_val = regs[rb_idx];
  assign f_val  = flags[f_idx];

  brnpc_unit i_brnpc_unit (
    .instr_i     (instr),
    .pc_i        (pc),
    .rs_a_idx_o  (ra_idx),
    .rs_b_idx_o  (rb_idx),
    .rs_a_val_i  (ra_val),
    .rs_b_val_i  (rb_val),
    .flag_idx_o  (f_idx),
    .flag_val_i  (f_val),
    .is_branch_o (is_br),
    .taken_o     (taken),
    .next_pc_o   (next_pc),
    .wb_en_o     (wb_en),
    .wb_idx_o    (wb_idx),
    .wb_data_o   (wb_data)
  );

  localparam logic [63:0] PC0 = 64'h0000_1234_0000_8000;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc16(input logic [5:0] m, input int off, input logic [4:0] rj, input logic [4:0] rd);
    logic [15:0] o = 16'(off);
    return {m, o, rj, rd};
  endfunction

  function automatic logic [31:0] enc21(input logic [5:0] m, input int off, input logic [4:0] mid);
    logic [20:0] o = 21'(off);
    return {m, o[15:0], mid, o[20:16]};
  endfunction

  function automatic logic [31:0] enc26(input logic [5:0] m, input int off);
    logic [25:0] o = 26'(off);
    return {m, o[15:0], o[25:16]};
  endfunction

  function automatic logic [63:0] rel(input int off);
    longint o = off;
    return PC0 + 64'(o * 4);
  endfunction

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    pc    = PC0;
    #2;
  endtask

  task automatic t_idle;
    apply(32'h0);
    check("R1 idle is_branch", 64'(is_br), 0);
    check("R1 idle wb_en", 64'(wb_en), 0);
    check("R7 idle next", next_pc, PC0 + 4);
    apply(32'h7000_0000);
    check("R1 major 0x1C not branch", 64'(is_br), 0);
    apply(32'h3C00_0000);
    check("R1 major 0x0F not branch", 64'(taken), 0);
    apply(32'h4800_0200);
    check("R3 flag word bit9 set not branch", 64'(is_br), 0);
    check("R7 flag word bit9 next", next_pc, PC0 + 4);
  endtask

  task automatic t_zero;
    regs[5] = 0;
    apply(enc21(6'h10, -1, 5'd5));
    check("R2 zero taken", 64'(taken), 1);
    check("R2 zero back one word", next_pc, rel(-1));
    apply(enc21(6'h10, 21'h0FFFFF, 5'd5));
    check("R2 zero max positive offset", next_pc, rel(32'h0FFFFF));
    apply(enc21(6'h11, 8, 5'd5));
    check("R7 nonzero on zero not taken", next_pc, PC0 + 4);
    regs[5] = 64'h8000_0000_0000_0000;
    apply(enc21(6'h11, 8, 5'd5));
    check("R2 nonzero on top bit only", next_pc, rel(8));
    apply(enc21(6'h10, 8, 5'd5));
    check("R2 zero on top bit only", 64'(taken), 0);
  endtask

  task automatic t_flag;
    flags = 8'b0010_0000;
    apply(enc21(6'h12, 3, {2'b00, 3'd5}));
    check("R3 flag index", 64'(f_idx), 5);
    check("R3 clear-test on set flag", 64'(taken), 0);
    apply(enc21(6'h12, 3, {2'b00, 3'd4}));
    check("R3 clear-test on clear flag", next_pc, rel(3));
    apply(enc21(6'h12, -32'h100000, {2'b01, 3'd5}));
    check("R3 set-test min offset", next_pc, rel(-32'h100000));
    apply(enc21(6'h12, 3, {2'b01, 3'd7}));
    check("R3 set-test on clear flag", 64'(taken), 0);
  endtask

  task automatic t_eq;
    regs[6] = 42; regs[7] = 42;
    apply(enc16(6'h16, 16'h7FFF, 5'd6, 5'd7));
    check("R4 equal max offset", next_pc, rel(32'h7FFF));
    apply(enc16(6'h17, 5, 5'd6, 5'd7));
    check("R4 not-equal on equal", next_pc, PC0 + 4);
    regs[7] = 64'h1_0000_002A;
    apply(enc16(6'h17, -32768, 5'd6, 5'd7));
    check("R4 not-equal high bits differ", next_pc, rel(-32768));
    apply(enc16(6'h16, 5, 5'd6, 5'd7));
    check("R4 equal high bits differ", 64'(taken), 0);
  endtask

  task automatic t_compare;
    regs[8] = 64'hFFFF_FFFF_FFFF_FFFF; regs[9] = 1;
    apply(enc16(6'h18, 2, 5'd8, 5'd9));
    check("R5 signed less -1<1", 64'(taken), 1);
    apply(enc16(6'h19, 2, 5'd8, 5'd9));
    check("R5 signed ge -1>=1", 64'(taken), 0);
    apply(enc16(6'h1A, 2, 5'd8, 5'd9));
    check("R6 unsigned less max<1", 64'(taken), 0);
    apply(enc16(6'h1B, -2, 5'd8, 5'd9));
    check("R6 unsigned ge max>=1", next_pc, rel(-2));
    apply(enc16(6'h19, 6, 5'd9, 5'd9));
    check("R5 signed ge equal operands", next_pc, rel(6));
    apply(enc16(6'h1A, 6, 5'd9, 5'd9));
    check("R6 unsigned less equal operands", 64'(taken), 0);
  endtask

  task automatic t_jump;
    apply(enc26(6'h14, -32'h2000000));
    check("R8 branch min offset", next_pc, rel(-32'h2000000));
    check("R8 branch no link", 64'(wb_en), 0);
    apply(enc26(6'h14, 32'h1FFFFFF));
    check("R8 branch max offset", next_pc, rel(32'h1FFFFFF));
    apply(enc26(6'h15, 16));
    check("R9 call target", next_pc, rel(16));
    check("R9 call wb_en", 64'(wb_en), 1);
    check("R9 call wb_idx", 64'(wb_idx), 1);
    check("R9 call wb_data", wb_data, PC0 + 4);
  endtask

  task automatic t_jirl;
    regs[12] = 64'h0000_0000_0000_2000;
    apply(enc16(6'h13, -2, 5'd12, 5'd12));
    check("R10 jump target from old rj", next_pc, 64'h1FF8);
    check("R10 jump wb_idx", 64'(wb_idx), 12);
    check("R10 jump wb_data", wb_data, PC0 + 4);
    apply(enc16(6'h13, 4, 5'd12, 5'd0));
    check("R11 link to r0 dropped", 64'(wb_en), 0);
    check("R11 target still used", next_pc, 64'h2010);
  endtask

  task automatic t_idx;
    apply(enc16(6'h16, 1, 5'd17, 5'd22));
    check("R12 first index", 64'(ra_idx), 17);
    check("R12 second index", 64'(rb_idx), 22);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = '0;
    flags = '0;
    instr = '0;
    pc    = PC0;
    t_idle;
    t_zero;
    t_flag;
    t_eq;
    t_compare;
    t_jump;
    t_jirl;
    t_idx;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule